// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a 16-bit serial analog-to-digital converter and runs its sample cycles. Each cycle has three steps. The block raises a conversion-control output and holds it high for a fixed number of system clocks, which covers the conversion time. It then drops that line, which starts the converter's acquisition and enables its data output. Finally it generates a serial clock and assembles the returned word, most significant bit first.

A cycle starts from a one-cycle trigger pulse or from a free-running enable. Two limits set the spacing between cycle starts. One is a cycle-period parameter. The other is a floor derived from the system clock frequency and the converter's 150 ksps ceiling, so the converter is never overdriven. A trigger that arrives while a cycle is running, or before the spacing has elapsed, is held and served later. The finished word appears on a parallel bus together with a one-cycle valid strobe.

Top module: `adc_read_ctrl`

## Requirements
- R1: During and after reset, `conv_o`, `sclk_o`, `valid_o` and `busy_o` are low and `data_o` is zero.
- R2: Once a cycle starts, `conv_o` is high for exactly `CONV_WAIT` system clocks, and `sclk_o` stays low the whole time.
- R3: After `conv_o` falls, `sclk_o` idles low and gives exactly 16 pulses. Its k-th rising edge (k = 1..16) comes `SCLK_HALF + (k-1)*2*SCLK_HALF` clocks after the fall, and each high or low phase lasts `SCLK_HALF` clocks.
- R4: `sdo_i` is sampled at the system edge on which `sclk_o` rises. The first sampled bit becomes `data_o[15]` and the 16th becomes `data_o[0]`.
- R5: Levels on `sdo_i` after the 16th rising edge of `sclk_o` have no effect on `data_o`. No 17th rising edge is generated.
- R6: `valid_o` is a one-clock pulse `32*SCLK_HALF` clocks after `conv_o` falls, with the new word on `data_o`. `data_o` holds that word until the next pulse.
- R7: `busy_o` rises with `conv_o` and stays high until the clock of the `valid_o` pulse, in which it is low.
- R8: Two cycle starts are at least `EFF` clocks apart, where `EFF` is the largest of `CYCLE_PERIOD`, ceil(`SYS_HZ`/`MAX_SPS`) and `CONV_WAIT + 32*SCLK_HALF + 1`. With `free_run_i` held high, starts are exactly `EFF` clocks apart.
- R9: A `trigger_i` pulse that arrives while busy or inside the spacing window is held. The held cycle starts exactly `EFF` clocks after the previous start. Several such pulses collapse into one cycle.
- R10: A `trigger_i` pulse seen while idle, with the spacing window expired, makes `conv_o` high on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_run_i | input | 1 | Start cycles back to back at the spacing limit while high |
| trigger_i | input | 1 | One-clock request for a single cycle |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion control, high while converting |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| data_o | output | DATA_W | Last assembled word |
| valid_o | output | 1 | One-clock strobe with a new word |
| busy_o | output | 1 | High from cycle start until the strobe |

## Verification
The bench overrides the cycle period with a value below the rate floor. A design that ignored the 150 ksps ceiling would then start cycles too early, and the bench measures every start-to-start gap against the clamped value. The converter model drives ones after the last bit. An extra clock pulse or a late capture edge would therefore corrupt an all-zero word, and a capture on the wrong edge would shift the word by one bit. Triggers are also issued during a running cycle. A controller that dropped them would lose a frame, one that counted them would add a frame, and one that ignored the spacing would start the held cycle too soon.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } rd_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_rd_pacer.sv
module adc_rd_pacer #(
    parameter int PERIOD = 334
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic free_run_i,
    input  logic trigger_i,
    output logic start_o
);
    localparam int TW = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [TW-1:0] timer;
        logic          pend;
    } pacer_t;

    pacer_t pc_d, pc_q;

    always_comb begin
        start_o = idle_i && (pc_q.timer == '0) && (pc_q.pend || trigger_i || free_run_i);
        pc_d = pc_q;
        if (start_o) begin
            pc_d.timer = TW'(PERIOD - 1);
            pc_d.pend  = 1'b0;
        end else begin
            if (pc_q.timer != '0) pc_d.timer = pc_q.timer - 1'b1;
            pc_d.pend = pc_q.pend | trigger_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // R9: a held request survives until a cycle is actually started
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q.pend && !start_o) |=> pc_q.pend);
    // R9: serving a held request consumes it
    a_r9_request_served: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !trigger_i) |=> !pc_q.pend);

endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } sck_t;

    sck_t sk_d, sk_q;
    logic edge_now;

    always_comb begin
        edge_now = run_i && (sk_q.cnt == CW'(HALF - 1));
        rise_o   = edge_now && !sk_q.sclk;
        fall_o   = edge_now && sk_q.sclk;
        sk_d     = sk_q;
        if (!run_i) begin
            sk_d.cnt  = '0;
            sk_d.sclk = 1'b0;
        end else if (edge_now) begin
            sk_d.cnt  = '0;
            sk_d.sclk = !sk_q.sclk;
        end else begin
            sk_d.cnt = sk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= '0;
        else        sk_q <= sk_d;
    end

    assign sclk_o = sk_q.sclk;

    // R3: the serial clock rests low whenever no read is running
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sk_q.sclk);

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear_i)      sh_d = '0;
        else if (shift_i) sh_d = {sh_q[W-2:0], din_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word_o = sh_q;

    // R4: each capture moves the previous bits one place toward the MSB
    a_r4_shift_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clear_i) |=> (sh_q[W-1:1] == $past(sh_q[W-2:0])));

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adc_rd_pkg::*;
#(
    parameter int SYS_HZ       = 50_000_000,
    parameter int MAX_SPS      = 150_000,
    parameter int CYCLE_PERIOD = 400,
    parameter int CONV_WAIT    = 200,
    parameter int SCLK_HALF    = 2,
    parameter int DATA_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              free_run_i,
    input  logic              trigger_i,
    input  logic              sdo_i,
    output logic              conv_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              busy_o
);
    localparam int MIN_GAP = (SYS_HZ + MAX_SPS - 1) / MAX_SPS;
    localparam int FRAME   = CONV_WAIT + 2 * DATA_W * SCLK_HALF + 1;
    localparam int EFF     = max3(CYCLE_PERIOD, MIN_GAP, FRAME);
    localparam int CW      = (CONV_WAIT > 1) ? $clog2(CONV_WAIT) : 1;
    localparam int BW      = $clog2(DATA_W + 1);
    localparam int GW      = $clog2(EFF + 1);

    typedef struct packed {
        rd_state_e         state;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     bits;
        logic [DATA_W-1:0] data;
        logic              valid;
    } ctl_t;

    ctl_t ct_d, ct_q;
    logic start, sck_rise, sck_fall, sck_level;
    logic [DATA_W-1:0] word;

    adc_rd_pacer #(.PERIOD(EFF)) i_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_i     (ct_q.state == ST_IDLE),
        .free_run_i (free_run_i),
        .trigger_i  (trigger_i),
        .start_o    (start)
    );

    adc_rd_sclk #(.HALF(SCLK_HALF)) i_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ct_q.state == ST_READ),
        .sclk_o (sck_level),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    adc_rd_shift #(.W(DATA_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start),
        .shift_i (sck_rise),
        .din_i   (sdo_i),
        .word_o  (word)
    );

    always_comb begin
        ct_d       = ct_q;
        ct_d.valid = 1'b0;
        unique case (ct_q.state)
            ST_IDLE: begin
                if (start) begin
                    ct_d.state = ST_CONV;
                    ct_d.cnt   = '0;
                    ct_d.bits  = '0;
                end
            end
            ST_CONV: begin
                if (ct_q.cnt == CW'(CONV_WAIT - 1)) begin
                    ct_d.state = ST_READ;
                    ct_d.cnt   = '0;
                end else begin
                    ct_d.cnt = ct_q.cnt + 1'b1;
                end
            end
            ST_READ: begin
                if (sck_rise) ct_d.bits = ct_q.bits + 1'b1;
                if (sck_fall && ct_q.bits == BW'(DATA_W)) begin
                    ct_d.state = ST_IDLE;
                    ct_d.valid = 1'b1;
                    ct_d.data  = word;
                end
            end
            default: ct_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_q       <= '0;
            ct_q.state <= ST_IDLE;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign conv_o  = (ct_q.state == ST_CONV);
    assign busy_o  = (ct_q.state != ST_IDLE);
    assign sclk_o  = sck_level;
    assign data_o  = ct_q.data;
    assign valid_o = ct_q.valid;

    // Checker state: clocks since the last observed conversion start
    logic          conv_prev_q;
    logic [GW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_prev_q <= 1'b0;
            since_q     <= GW'(EFF);
        end else begin
            conv_prev_q <= conv_o;
            if (conv_o && !conv_prev_q)  since_q <= GW'(1);
            else if (since_q < GW'(EFF)) since_q <= since_q + 1'b1;
        end
    end

    // R8: starts never come closer than the effective spacing
    a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_o && !conv_prev_q) |-> (since_q >= GW'(EFF)));
    // R2: no serial clock while conversion control is high
    a_r2_quiet_clock: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> !sclk_o);
    // R7: busy covers the conversion phase
    a_r7_busy_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> busy_o);
    // R7: the strobe coincides with the end of busy
    a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!busy_o && $past(busy_o)));
    // R6: strobe lasts one clock
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R5: never more rising serial clocks than word bits
    a_r5_bit_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q.bits <= BW'(DATA_W));
    // R6: the word only changes together with the strobe
    a_r6_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || $stable(data_o)));

endmodule

// File: tb/test_adc_read_ctrl.sv
module test_adc_read_ctrl;
    localparam int SYS_HZ  = 50_000_000;
    localparam int MAX_SPS = 150_000;
    localparam int PERIOD  = 100;
    localparam int CWAIT   = 40;
    localparam int H       = 3;
    // R8: period below the rate floor, so spacing is ceil(50e6/150e3) = 334
    localparam int EFF     = 334;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic free_run = 1'b0;
    logic trigger = 1'b0;
    logic sdo = 1'b0;
    logic conv, sclk, valid, busy;
    logic [15:0] data;

    always #10 clk = ~clk;

    adc_read_ctrl #(
        .SYS_HZ(SYS_HZ), .MAX_SPS(MAX_SPS), .CYCLE_PERIOD(PERIOD),
        .CONV_WAIT(CWAIT), .SCLK_HALF(H), .DATA_W(16)
    ) i_adc_read_ctrl (
        .clk(clk), .rst_n(rst_n), .free_run_i(free_run), .trigger_i(trigger),
        .sdo_i(sdo), .conv_o(conv), .sclk_o(sclk), .data_o(data),
        .valid_o(valid), .busy_o(busy)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] dev_q[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic push_word(input logic [15:0] w, input string req);
        exp_q.push_back(w);
        tag_q.push_back(req);
        dev_q.push_back(w);
    endtask

    // Converter model: MSB after conv falls, next bit per sclk fall, then ones
    bit in_frame = 1'b0;
    int idx = 0;
    logic [15:0] cur = '0;
    always @(posedge conv) begin
        in_frame = 1'b0;
        sdo = 1'b0;
    end
    always @(negedge conv or negedge sclk) begin
        if (rst_n) begin
            if (!in_frame && !conv) begin
                cur = (dev_q.size() != 0) ? dev_q.pop_front() : 16'h0;
                idx = 15;
                sdo = cur[15];
                in_frame = 1'b1;
            end else if (in_frame) begin
                if (idx > 0) begin
                    idx--;
                    sdo = cur[idx];
                end else begin
                    sdo = 1'b1;
                end
            end
        end
    end

    // Monitor / scoreboard
    longint cyc = 0, t_rise = 0, t_fall = 0;
    bit have_rise = 1'b0, sclk_in_conv = 1'b0;
    int n_conv = 0, rises = 0;
    int exact_from = 1 << 30;
    logic conv_p = 1'b0, sclk_p = 1'b0, valid_p = 1'b0, busy_p = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (conv && !conv_p) begin
                if (have_rise) begin
                    chk((cyc - t_rise) >= EFF, "R8 min spacing", cyc - t_rise, EFF);
                    if (n_conv >= exact_from)
                        chk((cyc - t_rise) == EFF, "R8/R9 exact spacing", cyc - t_rise, EFF);
                end
                t_rise = cyc;
                have_rise = 1'b1;
                n_conv++;
                sclk_in_conv = 1'b0;
            end
            if (conv && sclk) sclk_in_conv = 1'b1;
            if (!conv && conv_p) begin
                chk((cyc - t_rise) == CWAIT, "R2 conv width", cyc - t_rise, CWAIT);
                chk(!sclk_in_conv, "R2 sclk quiet", sclk_in_conv, 0);
                t_fall = cyc;
                rises = 0;
            end
            if (sclk && !sclk_p) begin
                rises++;
                chk((cyc - t_fall) == H + (rises - 1) * 2 * H, "R3 sclk timing",
                    cyc - t_fall, H + (rises - 1) * 2 * H);
            end
            if (valid) begin
                chk(!valid_p, "R6 one-cycle strobe", valid_p, 0);
                chk(rises == 16, "R3/R5 pulse count", rises, 16);
                chk((cyc - t_fall) == 32 * H, "R6 strobe time", cyc - t_fall, 32 * H);
                chk(!busy && busy_p, "R7 busy end", {busy_p, busy}, 2'b10);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected word", data, 0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(data == e, t, data, e);
                end
            end
            if (conv_p && !conv) chk(busy, "R7 busy in read", busy, 1);
        end
        conv_p = conv; sclk_p = sclk; valid_p = valid; busy_p = busy;
    end

    task automatic wait_drained();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_trigger();
        @(negedge clk);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk({conv, sclk, valid, busy} == 4'b0, "R1 reset outputs", {conv, sclk, valid, busy}, 0);
        chk(data == 16'h0, "R1 reset data", data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk({conv, sclk, valid, busy} == 4'b0, "R1 idle after reset", {conv, sclk, valid, busy}, 0);

        // R10: immediate start from idle
        push_word(16'hA5C3, "R4 word A5C3");
        pulse_trigger();
        chk(conv == 1'b1, "R10 start next edge", conv, 1);
        chk(busy == 1'b1, "R7 busy at start", busy, 1);
        wait_drained();
        chk(data == 16'hA5C3, "R6 data holds", data, 16'hA5C3);

        // R4/R5: edge patterns; the model drives ones after bit 0
        push_word(16'h0000, "R5 zeros despite trailing ones");
        pulse_trigger();
        wait_drained();
        repeat (EFF) @(negedge clk);
        push_word(16'hFFFF, "R4 all ones");
        pulse_trigger();
        wait_drained();
        repeat (EFF) @(negedge clk);
        push_word(16'h8001, "R4 msb and lsb");
        pulse_trigger();
        wait_drained();
        repeat (EFF) @(negedge clk);
        push_word(16'h7FFE, "R4 inner ones");
        pulse_trigger();
        wait_drained();
        repeat (EFF) @(negedge clk);

        // R9: triggers during a running cycle are held and collapse into one
        base = n_conv;
        exact_from = n_conv + 1;
        push_word(16'h1234, "R9 first frame");
        push_word(16'hFEDC, "R9 held frame");
        pulse_trigger();
        repeat (20) @(negedge clk);
        pulse_trigger();
        repeat (5) @(negedge clk);
        pulse_trigger();
        wait_drained();
        repeat (2 * EFF) @(negedge clk);
        chk(n_conv == base + 2, "R9 one held cycle", n_conv - base, 2);
        exact_from = 1 << 30;

        // R8: free running at the clamped spacing
        repeat (EFF) @(negedge clk);
        base = n_conv;
        exact_from = n_conv + 1;
        push_word(16'h0F0F, "R8 free run 1");
        push_word(16'hC0DE, "R8 free run 2");
        push_word(16'h5AA5, "R8 free run 3");
        push_word(16'h3C96, "R8 free run 4");
        @(negedge clk);
        free_run = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        free_run = 1'b0;
        repeat (2 * EFF) @(negedge clk);
        chk(n_conv == base + 4, "R8 free run count", n_conv - base, 4);
        chk(conv == 1'b0 && busy == 1'b0, "R7 idle after free run", {conv, busy}, 0);

        finish_run();
    end

endmodule